// File: doc/BRIEF.md
# Bit-Granular Packing FIFO

This block queues single bits, not words. A 37-bit word that enters on the write stream is split into bits and appended to the tail of the queue. The input operation chooses which bits are appended and in what order. On the read side, the output operation says how many head bits to throw away, how many of the following bits to gather into the next 37-bit word, and whether that word is sign-extended. Occupancy is counted in bits, and the queue holds up to 74 bits, which is two full words.

Each operation stays in force for every later word until a new one is loaded through its port. Typical uses are re-slicing a stream into fields of other widths, reversing bit order, and sampling one bit out of every 38.

The write and read data streams use valid/ready with back-pressure. A word moves only on a cycle where both valid and ready are high. The sender must hold its data stable while valid is high and ready is low. `wr_ready` rises only when the free bit space can take the input take count. `rd_valid` rises only when the queue holds at least drop plus take bits. Once `rd_valid` is high, `rd_data` holds its value until it is read or a new output operation is loaded. Both operation ports are always ready. An operation loaded in a cycle applies from the next cycle on, so a data transfer in that same cycle still uses the old operation.

Top module: `bit_pack_fifo`

## Requirements
- R1: A synchronous reset empties the queue. After reset `rd_valid` is 0 and `wr_ready` is 1. The input operation becomes LSB-first with take 37, and the output operation becomes drop 0, take 37, no sign extension, so one written word reads back unchanged.
- R2: `wr_ready` is 1 exactly when 74 minus the stored bit count is at least the input take count.
- R3: The input field `iop_data[6]` selects the order. When it is 1, word bits 0, 1, 2 and upward are appended. When it is 0, bits 36, 35 and downward are appended.
- R4: The input field `iop_data[5:0]` sets how many bits of each accepted word are appended. The other bits of the word are ignored. A value above 37 acts as 37.
- R5: `rd_valid` is 1 exactly when the stored bit count is at least drop plus take of the output operation.
- R6: The output fields are take at `oop_data[5:0]` and drop at `oop_data[11:6]`. Values above 37 act as 37. On a read, drop head bits are discarded. The next take bits are placed at `rd_data` bit 0 upward in dequeue order, and the bits above them are 0.
- R7: When `oop_data[12]` is 1 and take is not 0, the last taken bit is copied into every bit of `rd_data` above the taken bits.
- R8: With drop 37 and take 1, consecutive reads return head bits 37, 75, 113 and so on of the written stream. So one bit out of every 38 is kept.
- R9: Both operation ports are always ready. A loaded operation applies from the next cycle and stays in force until it is replaced.
- R10: A write and a read in the same cycle are both carried out. The stored count changes by the appended bits minus the removed bits, and it never exceeds 74.
- R11: While `rd_valid` is 1 and `rd_ready` is 0, and no output operation is loaded, `rd_valid` stays 1 and `rd_data` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Room for the input take count |
| wr_data | input | 37 | Write word |
| iop_valid | input | 1 | Load a new input operation |
| iop_ready | output | 1 | Always 1 |
| iop_data | input | 7 | [6] LSB-first, [5:0] take |
| oop_valid | input | 1 | Load a new output operation |
| oop_ready | output | 1 | Always 1 |
| oop_data | input | 13 | [12] sign extend, [11:6] drop, [5:0] take |
| rd_valid | output | 1 | Output word available |
| rd_ready | input | 1 | Consumer accepts the output word |
| rd_data | output | 37 | Packed output word |

## Verification
The bit count sits behind both handshakes. If it is off by even one bit, `wr_ready` or `rd_valid` disagrees with a bit-level reference queue at the first boundary where the count matters. That usually happens within a few words. A bit placed at the wrong position, or a stale bit left above the tail, shows up in `rd_data` on the first read that covers it. This includes zero-fill and sign-fill errors. The bench compares both ready/valid flags every cycle, and compares the data on every cycle where a word is offered. Errors therefore surface in the same cycle as the first divergence.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
  parameter int WORD_W = 37;
  parameter int DEPTH  = 2 * WORD_W;
  parameter int FLD_W  = $clog2(WORD_W + 1);
  parameter int OCC_W  = $clog2(DEPTH + 1);

  typedef struct packed {
    logic             lsb_first;
    logic [FLD_W-1:0] take;
  } in_op_t;

  typedef struct packed {
    logic             sext;
    logic [FLD_W-1:0] drop;
    logic [FLD_W-1:0] take;
  } out_op_t;

  function automatic logic [FLD_W-1:0] clamp_fld(input logic [FLD_W-1:0] v);
    return (int'(v) > WORD_W) ? FLD_W'(WORD_W) : v;
  endfunction

  function automatic logic [WORD_W-1:0] low_mask(input logic [FLD_W-1:0] n);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) m[i] = (i < int'(n));
    return m;
  endfunction
endpackage

// File: rtl/bpf_unpack.sv
module bpf_unpack
  import bpf_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  in_op_t            op,
  output logic [WORD_W-1:0] bits
);
  logic [WORD_W-1:0] rev;

  for (genvar g = 0; g < WORD_W; g++) begin : g_rev
    assign rev[g] = word[WORD_W-1-g];
  end

  assign bits = (op.lsb_first ? word : rev) & low_mask(op.take);
endmodule

// File: rtl/bpf_pack.sv
module bpf_pack
  import bpf_pkg::*;
(
  input  logic [DEPTH-1:0]  store,
  input  out_op_t           op,
  output logic [WORD_W-1:0] word
);
  logic [DEPTH-1:0]  after_drop;
  logic [WORD_W-1:0] keep_mask;
  logic [WORD_W-1:0] field;
  logic [FLD_W-1:0]  top_idx;
  logic              sign_bit;

  always_comb begin
    after_drop = store >> op.drop;
    keep_mask  = low_mask(op.take);
    field      = after_drop[WORD_W-1:0] & keep_mask;
    top_idx    = op.take - FLD_W'(1);
    sign_bit   = (op.take != '0) && field[top_idx];
    word       = field | ((op.sext && sign_bit) ? ~keep_mask : '0);
  end
endmodule

// File: rtl/bpf_store.sv
module bpf_store
  import bpf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enq,
  input  logic [WORD_W-1:0] enq_bits,
  input  logic [OCC_W-1:0]  enq_n,
  input  logic              deq,
  input  logic [OCC_W-1:0]  deq_n,
  output logic [DEPTH-1:0]  store,
  output logic [OCC_W-1:0]  count
);
  logic [DEPTH-1:0] shifted;
  logic [OCC_W-1:0] base;
  logic [DEPTH-1:0] placed;

  always_comb begin
    shifted = deq ? (store >> deq_n) : store;
    base    = deq ? (count - deq_n) : count;
    placed  = {{(DEPTH-WORD_W){1'b0}}, enq_bits} << base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store <= '0;
      count <= '0;
    end else begin
      store <= enq ? (shifted | placed) : shifted;
      count <= enq ? (base + enq_n) : base;
    end
  end

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= DEPTH);

  assert_idle_count_R10: assert property (@(posedge clk) disable iff (rst)
    (!enq && !deq) |=> $stable(count) && $stable(store));
endmodule

// File: rtl/bit_pack_fifo.sv
module bit_pack_fifo
  import bpf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              iop_valid,
  output logic              iop_ready,
  input  logic [FLD_W:0]    iop_data,
  input  logic              oop_valid,
  output logic              oop_ready,
  input  logic [2*FLD_W:0]  oop_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data
);
  in_op_t           iop_q;
  out_op_t          oop_q;
  logic [DEPTH-1:0] store;
  logic [OCC_W-1:0] count;
  logic [WORD_W-1:0] enq_bits;
  logic [OCC_W-1:0] need;
  logic             wr_fire;
  logic             rd_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      iop_q <= '{lsb_first: 1'b1, take: FLD_W'(WORD_W)};
      oop_q <= '{sext: 1'b0, drop: '0, take: FLD_W'(WORD_W)};
    end else begin
      if (iop_valid)
        iop_q <= '{lsb_first: iop_data[FLD_W], take: clamp_fld(iop_data[FLD_W-1:0])};
      if (oop_valid)
        oop_q <= '{sext: oop_data[2*FLD_W], drop: clamp_fld(oop_data[2*FLD_W-1:FLD_W]),
                   take: clamp_fld(oop_data[FLD_W-1:0])};
    end
  end

  assign iop_ready = 1'b1;
  assign oop_ready = 1'b1;
  assign need      = OCC_W'(oop_q.drop) + OCC_W'(oop_q.take);
  assign wr_ready  = (OCC_W'(DEPTH) - count) >= OCC_W'(iop_q.take);
  assign rd_valid  = count >= need;
  assign wr_fire   = wr_valid && wr_ready;
  assign rd_fire   = rd_valid && rd_ready;

  bpf_unpack u_unpack (
    .word (wr_data),
    .op   (iop_q),
    .bits (enq_bits)
  );

  bpf_store u_store (
    .clk      (clk),
    .rst      (rst),
    .enq      (wr_fire),
    .enq_bits (enq_bits),
    .enq_n    (OCC_W'(iop_q.take)),
    .deq      (rd_fire),
    .deq_n    (need),
    .store    (store),
    .count    (count)
  );

  bpf_pack u_pack (
    .store (store),
    .op    (oop_q),
    .word  (rd_data)
  );

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready && !oop_valid) |=> rd_valid && $stable(rd_data));

  assert_wr_room_R2: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> int'(count) <= DEPTH);

  assert_sign_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && oop_q.sext && oop_q.take != '0)
      |-> rd_data[WORD_W-1] == rd_data[oop_q.take - FLD_W'(1)]);

  assert_ops_ready_R9: assert property (@(posedge clk) disable iff (rst)
    iop_ready && oop_ready);
endmodule

// File: tb/test_bit_pack_fifo.sv
`timescale 1ns/1ps
module test_bit_pack_fifo;
  localparam int W = 37;
  localparam int D = 74;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0, iop_valid = 1'b0, oop_valid = 1'b0, rd_ready = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [6:0] iop_data = '0;
  logic [12:0] oop_data = '0;
  logic wr_ready, iop_ready, oop_ready, rd_valid;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  bit q[$];
  bit m_ilsb;
  int m_itake, m_odrop, m_otake;
  bit m_osext;
  bit prev_hold = 0;
  logic [W-1:0] prev_data;

  always #5 clk = ~clk;

  bit_pack_fifo i_bit_pack_fifo (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .iop_valid(iop_valid), .iop_ready(iop_ready), .iop_data(iop_data),
    .oop_valid(oop_valid), .oop_ready(oop_ready), .oop_data(oop_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  function automatic int clampv(input int v);
    return (v > W) ? W : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    q.delete();
    m_ilsb = 1; m_itake = W; m_odrop = 0; m_otake = W; m_osext = 0;
    prev_hold = 0;
  endtask

  task automatic cyc(input logic iv, input logic [W-1:0] id, input logic pv, input logic [6:0] pd,
                     input logic ov, input logic [12:0] od, input logic rr, input string tg);
    bit exp_ir, exp_ov;
    logic [W-1:0] ew;
    int need;
    @(negedge clk);
    wr_valid = iv; wr_data = id; iop_valid = pv; iop_data = pd;
    oop_valid = ov; oop_data = od; rd_ready = rr;
    #1;
    exp_ir = (D - q.size()) >= m_itake;
    chk(wr_ready === exp_ir, "R2", 64'(wr_ready), 64'(exp_ir));
    need = m_odrop + m_otake;
    exp_ov = q.size() >= need;
    chk(rd_valid === exp_ov, "R5", 64'(rd_valid), 64'(exp_ov));
    if (exp_ov) begin
      ew = '0;
      for (int k = 0; k < m_otake; k++) ew[k] = q[m_odrop + k];
      if (m_osext && m_otake > 0 && ew[m_otake-1])
        for (int k = m_otake; k < W; k++) ew[k] = 1'b1;
      chk(rd_data === ew, (tg == "R6" && m_osext) ? "R7" : tg, 64'(rd_data), 64'(ew));
      if (prev_hold) chk(rd_data === prev_data, "R11", 64'(rd_data), 64'(prev_data));
    end
    prev_hold = exp_ov && !rr && !ov;
    prev_data = rd_data;
    if (exp_ov && rr) for (int k = 0; k < need; k++) void'(q.pop_front());
    if (iv && exp_ir)
      for (int k = 0; k < m_itake; k++) q.push_back(m_ilsb ? id[k] : id[W-1-k]);
    if (pv) begin m_ilsb = pd[6]; m_itake = clampv(int'(pd[5:0])); end
    if (ov) begin
      m_osext = od[12]; m_odrop = clampv(int'(od[11:6])); m_otake = clampv(int'(od[5:0]));
    end
    if (q.size() > D) chk(0, "R10", 64'(q.size()), 64'(D));
  endtask

  function automatic logic [W-1:0] rw();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(rd_valid === 1'b0, "R1", 64'(rd_valid), 0);
    chk(wr_ready === 1'b1, "R1", 64'(wr_ready), 1);
    // R1: defaults give identity
    cyc(1, 37'h1A5A5A5A5A, 0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, 1, "R1");
    // R3: MSB-first order
    cyc(0, 0, 1, {1'b0, 6'd37}, 0, 0, 0, "R3");
    for (int i = 0; i < 20; i++) cyc(1, rw(), 0, 0, 0, 0, i[0], "R3");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 1, "R3");
    // R4: partial take and clamp above 37
    cyc(0, 0, 1, {1'b1, 6'd5}, 1, {1'b0, 6'd0, 6'd10}, 0, "R4");
    for (int i = 0; i < 30; i++) cyc(1, rw(), 0, 0, 0, 0, $urandom_range(0, 1), "R4");
    cyc(0, 0, 1, {1'b1, 6'd50}, 1, {1'b0, 6'd0, 6'd50}, 1, "R4");
    for (int i = 0; i < 30; i++) cyc(1, rw(), 0, 0, 0, 0, $urandom_range(0, 1), "R4");
    // R8: drop 37 take 1 with sign extension
    cyc(0, 0, 1, {1'b1, 6'd37}, 1, {1'b1, 6'd37, 6'd1}, 1, "R8");
    for (int i = 0; i < 80; i++) cyc($urandom_range(0, 1), rw(), 0, 0, 0, 0, $urandom_range(0, 1), "R8");
    // R6 / R7: random output shapes
    for (int i = 0; i < 400; i++)
      cyc($urandom_range(0, 1), rw(), ($urandom_range(0, 15) == 0), 7'($urandom()),
          ($urandom_range(0, 15) == 0), 13'($urandom()), $urandom_range(0, 1), "R6");
    // R9: frequent op changes together with transfers
    for (int i = 0; i < 400; i++)
      cyc($urandom_range(0, 3) != 0, rw(), $urandom_range(0, 1), {1'($urandom()), 6'($urandom_range(0, 40))},
          $urandom_range(0, 1), {1'($urandom()), 6'($urandom_range(0, 40)), 6'($urandom_range(0, 40))},
          $urandom_range(0, 3) != 0, "R9");
    // R10 / R11: steady traffic with back-pressure
    cyc(0, 0, 1, {1'b1, 6'd13}, 1, {1'b0, 6'd3, 6'd9}, 0, "R10");
    for (int i = 0; i < 3000; i++)
      cyc($urandom_range(0, 1), rw(), 0, 0, 0, 0, $urandom_range(0, 2) == 0, "R10");
    // R1: reset mid-stream
    @(negedge clk); rst = 1'b1; wr_valid = 0; iop_valid = 0; oop_valid = 0; rd_ready = 0;
    @(negedge clk); rst = 1'b0; model_reset();
    #1;
    chk(rd_valid === 1'b0, "R1", 64'(rd_valid), 0);
    cyc(1, 37'h0F0F0F0F0F, 0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, 1, "R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule